// File: doc/BRIEF.md
# Carry-chain extended add unit

This block is a one-stage integer execution slice for the extended add family. These operations begin, continue or finish a multi-word add or subtract whose carry moves from word to word through a single carry flag. Four operations are supported:

- add to minus one: A − 1 + carry
- add to zero: A + carry
- add with register: A + B + carry
- subtract from minus one: NOT A − 1 + carry

The issuing pipeline presents a 32-bit instruction word, the two source operand values, and the current carry, overflow and summary-overflow flags, together with a valid strobe. One cycle later the unit returns a registered bundle:

- the result and its destination register index
- separate write enables for the destination, the carry, the overflow pair and a 4-bit condition field
- the updated flag values
- an illegal indication when the instruction word is not one of the four operations

Register storage and instruction fetch sit outside the block. The block decodes the overflow-enable and record bits. It keeps the summary-overflow flag sticky. It builds a signed compare-with-zero condition field whose last bit mirrors the summary-overflow value after the update.

Top module: `ccx_unit`

## Requirements
- R1: An instruction is legal only when bits 31:26 of the word equal 31 and bits 9:1 equal 234, 202, 138 or 232. Any other word sets `illegal` with `outValid`, and `rdWe`, `carryWe`, `ovWe` and `crWe` all stay low.
- R2: Extended opcode 234 (bits 9:1) writes `opA + carryIn − 1`, wrapped to the data width, to the destination.
- R3: For extended opcode 234, `carryOut` is 0 only when `opA` is zero and `carryIn` is 0; otherwise it is 1.
- R4: Extended opcode 202 writes `opA + carryIn`, with `carryOut` equal to the carry out of the top bit.
- R5: Extended opcode 138 writes `opA + opB + carryIn`, with `carryOut` equal to the carry out of the top bit.
- R6: Extended opcode 232 writes `NOT opA + all-ones + carryIn`, with `carryOut` equal to the carry out of the top bit.
- R7: Every legal instruction asserts `carryWe` and `rdWe`, whatever the values of the OE bit (bit 10) and the Rc bit (bit 0).
- R8: With OE (bit 10) = 1, `ovWe` is high and `ovOut` is 1 exactly when the true signed sum differs from the wrapped signed result; `soOut` is `soIn` OR `ovOut`. With OE = 0, `ovWe` is low and `ovOut`/`soOut` equal `ovIn`/`soIn`.
- R9: With Rc (bit 0) = 1, `crWe` is high and `crField` = {LT, GT, EQ, SO}, bit 3 down to bit 0. Exactly one of LT, GT and EQ is set, from a signed compare of the result with zero, and SO equals `soOut`. With Rc = 0, `crWe` is low.
- R10: The register B field (bits 15:11) and the `opB` value are ignored by opcodes 234 and 202. A non-zero B field neither raises `illegal` nor changes the result.
- R11: Results appear exactly one cycle after an `inValid` strobe, with a one-cycle `outValid`. A synchronous reset clears `outValid` and all write enables, and no write enable is high without `outValid`.
- R12: `rdIdx` equals the destination field in bits 25:21 of the instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input bundle is valid this cycle |
| instr | input | 32 | Instruction word |
| opA | input | W | Source A operand value |
| opB | input | W | Source B operand value |
| carryIn | input | 1 | Current carry flag |
| ovIn | input | 1 | Current overflow flag |
| soIn | input | 1 | Current summary-overflow flag |
| outValid | output | 1 | Registered result bundle is valid |
| illegal | output | 1 | Instruction word was not recognised |
| rdIdx | output | 5 | Destination register index |
| rdData | output | W | Result value |
| rdWe | output | 1 | Destination write enable |
| carryOut | output | 1 | New carry flag |
| carryWe | output | 1 | Carry write enable |
| ovOut | output | 1 | New overflow flag |
| soOut | output | 1 | New summary-overflow flag |
| ovWe | output | 1 | Overflow and summary-overflow write enable |
| crField | output | 4 | Condition field {LT, GT, EQ, SO} |
| crWe | output | 1 | Condition field write enable |

## Verification
The block holds no state beyond its single output stage. A wrong decode or a mis-steered operand therefore shows up as a bad `rdData`, `carryOut` or write enable on the very next `outValid` cycle.

The hard cases are the borders of the carry and overflow predicates: zero operands with and without carry-in, and the most-negative and most-positive words. A sticky flag that gets cleared only shows when `soIn` is already set and the instruction has no overflow, so those inputs are driven on purpose. The condition field's SO bit is checked on the same instruction that first raises the overflow.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned PRIM_W   = 6;
  localparam int unsigned XOP_W    = 9;
  localparam int unsigned CR_W     = 4;

  localparam logic [PRIM_W-1:0] PRIM_CHAIN = 6'd31;
  localparam logic [XOP_W-1:0]  XOP_ADDM1  = 9'd234;
  localparam logic [XOP_W-1:0]  XOP_ADDZ   = 9'd202;
  localparam logic [XOP_W-1:0]  XOP_ADDR   = 9'd138;
  localparam logic [XOP_W-1:0]  XOP_SUBM1  = 9'd232;

  // condition field bit positions
  localparam int unsigned CR_LT = 3;
  localparam int unsigned CR_GT = 2;
  localparam int unsigned CR_EQ = 1;
  localparam int unsigned CR_SO = 0;

  // second adder operand source
  typedef enum logic [1:0] {
    B_ZERO = 2'd0,
    B_ONES = 2'd1,
    B_REG  = 2'd2
  } bSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             legal;
    logic             invA;
    bSel_e            bSel;
    logic             useOe;
    logic             useRc;
    logic [IDX_W-1:0] rtIdx;
  } ctrl_s;
endpackage

// File: rtl/ccx_ctrl.sv
module ccx_ctrl
  import ccx_pkg::*;
(
  input  logic [PRIM_W-1:0] primOp,
  input  logic [XOP_W-1:0]  extOp,
  input  logic [IDX_W-1:0]  rtField,
  input  logic              oeBit,
  input  logic              rcBit,
  output ctrl_s             ctl
);
  logic  primOk;
  logic  xopOk;
  logic  invSel;
  bSel_e bSrc;

  assign primOk = (primOp == PRIM_CHAIN);

  always_comb begin
    xopOk  = 1'b1;
    invSel = 1'b0;
    bSrc   = B_ZERO;
    case (extOp)
      XOP_ADDM1: begin invSel = 1'b0; bSrc = B_ONES; end
      XOP_ADDZ:  begin invSel = 1'b0; bSrc = B_ZERO; end
      XOP_ADDR:  begin invSel = 1'b0; bSrc = B_REG;  end
      XOP_SUBM1: begin invSel = 1'b1; bSrc = B_ONES; end
      default:   xopOk = 1'b0;
    endcase
  end

  always_comb begin
    ctl.legal = primOk && xopOk;
    ctl.invA  = invSel;
    ctl.bSel  = bSrc;
    ctl.useOe = ctl.legal && oeBit;
    ctl.useRc = ctl.legal && rcBit;
    ctl.rtIdx = rtField;
  end
endmodule

// File: rtl/ccx_datapath.sv
module ccx_datapath
  import ccx_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  ctrl_s          ctl,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic           carryIn,
  input  logic           ovIn,
  input  logic           soIn,
  output logic [W-1:0]   result,
  output logic           carryOut,
  output logic           ovOut,
  output logic           soOut,
  output logic [CR_W-1:0] crField
);
  localparam int unsigned SUM_W = W + 1;

  logic [W-1:0]     xOp;
  logic [W-1:0]     yOp;
  logic [SUM_W-1:0] sum;
  logic             ovRaw;
  logic             soNew;
  logic             isZero;
  logic             isNeg;

  assign xOp = ctl.invA ? ~opA : opA;

  always_comb begin
    case (ctl.bSel)
      B_ONES:  yOp = '1;
      B_REG:   yOp = opB;
      default: yOp = '0;
    endcase
  end

  assign sum      = {1'b0, xOp} + {1'b0, yOp} + {{W{1'b0}}, carryIn};
  assign result   = sum[W-1:0];
  assign carryOut = sum[W];

  // signed overflow: like-signed inputs giving a differently signed sum
  assign ovRaw = (xOp[W-1] == yOp[W-1]) && (result[W-1] != xOp[W-1]);

  assign ovOut = ctl.useOe ? ovRaw : ovIn;
  assign soNew = ctl.useOe ? (soIn | ovRaw) : soIn;
  assign soOut = soNew;

  assign isZero = (result == '0);
  assign isNeg  = result[W-1];

  always_comb begin
    crField        = '0;
    crField[CR_LT] = isNeg;
    crField[CR_GT] = !isNeg && !isZero;
    crField[CR_EQ] = isZero;
    crField[CR_SO] = soNew;
  end
endmodule

// File: rtl/ccx_unit.sv
module ccx_unit
  import ccx_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic              carryIn,
  input  logic              ovIn,
  input  logic              soIn,
  output logic              outValid,
  output logic              illegal,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [W-1:0]      rdData,
  output logic              rdWe,
  output logic              carryOut,
  output logic              carryWe,
  output logic              ovOut,
  output logic              soOut,
  output logic              ovWe,
  output logic [CR_W-1:0]   crField,
  output logic              crWe
);
  ctrl_s           ctl;
  logic [W-1:0]    dpResult;
  logic            dpCarry;
  logic            dpOv;
  logic            dpSo;
  logic [CR_W-1:0] dpCr;
  logic            unusedRegFields;

  // source register fields are resolved upstream; only their presence matters
  assign unusedRegFields = ^instr[20:11];

  ccx_ctrl u_ctrl (
    .primOp  (instr[31:26]),
    .extOp   (instr[9:1]),
    .rtField (instr[25:21]),
    .oeBit   (instr[10]),
    .rcBit   (instr[0]),
    .ctl     (ctl)
  );

  ccx_datapath #(.W(W)) u_dp (
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .ovIn     (ovIn),
    .soIn     (soIn),
    .result   (dpResult),
    .carryOut (dpCarry),
    .ovOut    (dpOv),
    .soOut    (dpSo),
    .crField  (dpCr)
  );

  // control half of the output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
      rdWe     <= 1'b0;
      carryWe  <= 1'b0;
      ovWe     <= 1'b0;
      crWe     <= 1'b0;
    end else begin
      outValid <= inValid;
      illegal  <= inValid && !ctl.legal;
      rdWe     <= inValid && ctl.legal;
      carryWe  <= inValid && ctl.legal;
      ovWe     <= inValid && ctl.useOe;
      crWe     <= inValid && ctl.useRc;
    end
  end

  // data half of the output stage, loaded on each strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rdIdx    <= '0;
      rdData   <= '0;
      carryOut <= 1'b0;
      ovOut    <= 1'b0;
      soOut    <= 1'b0;
      crField  <= '0;
    end else if (inValid) begin
      rdIdx    <= ctl.rtIdx;
      rdData   <= dpResult;
      carryOut <= dpCarry;
      ovOut    <= dpOv;
      soOut    <= dpSo;
      crField  <= dpCr;
    end
  end
endmodule

// File: rtl/ccx_checker.sv
module ccx_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [5:0]   prim,
  input logic [8:0]   xop,
  input logic [W-1:0] opA,
  input logic         carryIn,
  input logic         soIn,
  input logic         outValid,
  input logic         illegal,
  input logic         rdWe,
  input logic         carryWe,
  input logic         ovWe,
  input logic         crWe,
  input logic         carryOut,
  input logic         ovOut,
  input logic         soOut,
  input logic [3:0]   crField
);
  logic isAddm1;
  assign isAddm1 = (prim == 6'd31) && (xop == 9'd234);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  a_r11_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (rdWe || carryWe || ovWe || crWe) |-> outValid);
  a_r1_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rdWe && !carryWe && !ovWe && !crWe));
  a_r7_carry_always: assert property (@(posedge clk) disable iff (rst)
    (outValid && !illegal) |-> (carryWe && rdWe));
  a_r3_addm1_carry: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(isAddm1)) |->
      (carryOut == (($past(opA) != '0) || $past(carryIn))));
  a_r8_so_sticky: assert property (@(posedge clk) disable iff (rst)
    (outValid && ovWe) |-> (soOut == ($past(soIn) || ovOut)));
  a_r9_cr_onehot: assert property (@(posedge clk) disable iff (rst)
    crWe |-> ($countones(crField[3:1]) == 1));
  a_r9_cr_so: assert property (@(posedge clk) disable iff (rst)
    crWe |-> (crField[0] == soOut));
endmodule

bind ccx_unit ccx_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .prim     (instr[31:26]),
  .xop      (instr[9:1]),
  .opA      (opA),
  .carryIn  (carryIn),
  .soIn     (soIn),
  .outValid (outValid),
  .illegal  (illegal),
  .rdWe     (rdWe),
  .carryWe  (carryWe),
  .ovWe     (ovWe),
  .crWe     (crWe),
  .carryOut (carryOut),
  .ovOut    (ovOut),
  .soOut    (soOut),
  .crField  (crField)
);

// File: tb/ccx_unit_tb.sv
module ccx_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [31:0]  instr = '0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic         ovIn = 1'b0;
  logic         soIn = 1'b0;
  logic         outValid, illegal, rdWe, carryOut, carryWe, ovOut, soOut, ovWe, crWe;
  logic [4:0]   rdIdx;
  logic [W-1:0] rdData;
  logic [3:0]   crField;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ccx_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr), .opA(opA), .opB(opB),
    .carryIn(carryIn), .ovIn(ovIn), .soIn(soIn), .outValid(outValid),
    .illegal(illegal), .rdIdx(rdIdx), .rdData(rdData), .rdWe(rdWe),
    .carryOut(carryOut), .carryWe(carryWe), .ovOut(ovOut), .soOut(soOut),
    .ovWe(ovWe), .crField(crField), .crWe(crWe)
  );

  typedef struct {
    bit          ill;
    bit          oe;
    bit          rc;
    logic [4:0]  idx;
    logic [31:0] data;
    bit          ca;
    bit          ov;
    bit          so;
    logic [3:0]  cr;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] prim, input logic [8:0] xo,
      input logic [4:0] rt, input logic [4:0] ra, input logic [4:0] rb,
      input bit oe, input bit rc);
    return {prim, rt, ra, rb, oe, xo, rc};
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
      input logic [31:0] b, input bit c, input bit ov, input bit so, input string tag);
    exp_t e;
    longint x, y, ts, wrapped;
    logic [63:0] u;
    logic [8:0] xo;
    xo = w[9:1];
    e.tag = tag;
    e.oe  = w[10];
    e.rc  = w[0];
    e.idx = w[25:21];
    e.ill = !((w[31:26] == 6'd31) && (xo == 9'd234 || xo == 9'd202 ||
                                      xo == 9'd138 || xo == 9'd232));
    x = longint'($signed(a));
    y = 0;
    if (xo == 9'd232) x = -x - 1;
    if (xo == 9'd234 || xo == 9'd232) y = -1;
    if (xo == 9'd138) y = longint'($signed(b));
    ts = x + y + longint'(c);
    e.data = ts[31:0];
    u = {32'b0, x[31:0]} + {32'b0, y[31:0]} + {63'b0, c};
    e.ca = u[32];
    if (xo == 9'd234) e.ca = (a != 0) || c;
    wrapped = longint'($signed(e.data));
    e.ov = e.oe ? (ts != wrapped) : ov;
    e.so = e.oe ? (so | e.ov) : so;
    e.cr = {wrapped < 0, wrapped > 0, wrapped == 0, e.so};
    return e;
  endfunction

  task automatic send(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                      input bit c, input bit ov, input bit so, input string tag);
    @(negedge clk);
    instr = w; opA = a; opB = b; carryIn = c; ovIn = ov; soIn = so;
    inValid = 1'b1;
    sb.push_back(model(w, a, b, c, ov, so, tag));
  endtask

  task automatic idleCheck();
    @(negedge clk);
    inValid = 1'b0;
    instr = '1;
    @(negedge clk);
    chk(outValid == 1'b0, "R11", "outValid after gap", outValid, 0);
    chk({rdWe, carryWe, ovWe, crWe} == 4'b0, "R11", "enables after gap",
        {rdWe, carryWe, ovWe, crWe}, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11", "unexpected outValid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(illegal == e.ill, e.tag, "illegal", illegal, e.ill);
        chk(rdWe == !e.ill, e.tag, "rdWe", rdWe, !e.ill);
        chk(carryWe == !e.ill, e.tag, "carryWe", carryWe, !e.ill);
        chk(ovWe == (!e.ill && e.oe), e.tag, "ovWe", ovWe, !e.ill && e.oe);
        chk(crWe == (!e.ill && e.rc), e.tag, "crWe", crWe, !e.ill && e.rc);
        if (!e.ill) begin
          chk(rdIdx == e.idx, e.tag, "rdIdx", rdIdx, e.idx);
          chk(rdData == e.data, e.tag, "rdData", rdData, e.data);
          chk(carryOut == e.ca, e.tag, "carryOut", carryOut, e.ca);
          chk(ovOut == e.ov, e.tag, "ovOut", ovOut, e.ov);
          chk(soOut == e.so, e.tag, "soOut", soOut, e.so);
          if (e.rc) chk(crField == e.cr, e.tag, "crField", crField, e.cr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R11", "outValid in reset", outValid, 0);
    chk({rdWe, carryWe, ovWe, crWe} == 4'b0, "R11", "enables in reset",
        {rdWe, carryWe, ovWe, crWe}, 0);
    rst = 1'b0;

    // R2 basic add to minus one
    send(mk(31, 234, 3, 1, 0, 0, 0), 32'd5, 32'd0, 0, 0, 0, "R2");
    send(mk(31, 234, 4, 1, 0, 0, 0), 32'd5, 32'd0, 1, 0, 0, "R2");
    // R3 carry predicate corners
    send(mk(31, 234, 5, 2, 0, 0, 1), 32'd0, 32'd0, 0, 0, 0, "R3");
    send(mk(31, 234, 6, 2, 0, 0, 1), 32'd0, 32'd0, 1, 0, 0, "R3");
    send(mk(31, 234, 7, 2, 0, 0, 0), 32'h8000_0000, 32'd0, 0, 0, 0, "R3");
    // R4 add to zero
    send(mk(31, 202, 8, 1, 0, 0, 1), 32'hFFFF_FFFF, 32'd0, 1, 0, 0, "R4");
    send(mk(31, 202, 9, 1, 0, 0, 1), 32'h1234_5678, 32'd0, 0, 0, 0, "R4");
    // R5 add with register
    send(mk(31, 138, 10, 1, 2, 0, 1), 32'hFFFF_FFF0, 32'h0000_0020, 1, 0, 0, "R5");
    send(mk(31, 138, 11, 1, 2, 0, 0), 32'h0000_1000, 32'h0000_0234, 0, 0, 0, "R5");
    // R6 subtract from minus one
    send(mk(31, 232, 12, 1, 0, 0, 1), 32'd0, 32'd0, 0, 0, 0, "R6");
    send(mk(31, 232, 13, 1, 0, 0, 1), 32'hFFFF_FFFF, 32'd0, 0, 0, 0, "R6");
    send(mk(31, 232, 14, 1, 0, 0, 0), 32'h8000_0000, 32'd0, 1, 0, 0, "R6");
    // R7 carry written regardless of OE and Rc
    send(mk(31, 202, 15, 1, 0, 0, 0), 32'd7, 32'd0, 1, 1, 1, "R7");
    send(mk(31, 234, 15, 1, 0, 1, 1), 32'd7, 32'd0, 0, 0, 0, "R7");
    // R8 overflow set / clear / sticky / pass-through
    send(mk(31, 234, 16, 1, 0, 1, 0), 32'h8000_0000, 32'd0, 0, 0, 0, "R8");
    send(mk(31, 202, 17, 1, 0, 1, 0), 32'h7FFF_FFFF, 32'd0, 1, 0, 0, "R8");
    send(mk(31, 138, 18, 1, 2, 1, 0), 32'h7FFF_FFFF, 32'd1, 0, 0, 0, "R8");
    send(mk(31, 232, 19, 1, 0, 1, 0), 32'h7FFF_FFFF, 32'd0, 0, 0, 0, "R8");
    send(mk(31, 234, 20, 1, 0, 1, 0), 32'd9, 32'd0, 0, 1, 1, "R8");
    send(mk(31, 234, 21, 1, 0, 0, 0), 32'h8000_0000, 32'd0, 0, 1, 0, "R8");
    send(mk(31, 234, 22, 1, 0, 0, 0), 32'h8000_0000, 32'd0, 0, 0, 1, "R8");
    // R9 condition field with SO taken after update
    send(mk(31, 234, 23, 1, 0, 1, 1), 32'h8000_0000, 32'd0, 0, 0, 0, "R9");
    send(mk(31, 138, 24, 1, 2, 0, 1), 32'hFFFF_FFF0, 32'd1, 0, 0, 1, "R9");
    send(mk(31, 202, 25, 1, 0, 0, 1), 32'd0, 32'd0, 0, 0, 0, "R9");
    send(mk(31, 232, 26, 1, 0, 1, 1), 32'h0000_0004, 32'd0, 1, 0, 1, "R9");
    // R10 B field and opB ignored by 234 and 202
    send(mk(31, 234, 27, 1, 31, 0, 1), 32'd100, 32'hDEAD_BEEF, 1, 0, 0, "R10");
    send(mk(31, 202, 28, 1, 17, 1, 0), 32'd100, 32'hFFFF_FFFF, 1, 0, 0, "R10");
    // R1 illegal words
    send(mk(30, 234, 29, 1, 0, 1, 1), 32'd1, 32'd0, 1, 0, 0, "R1");
    send(mk(31, 235, 29, 1, 0, 1, 1), 32'd1, 32'd0, 1, 0, 0, "R1");
    send(mk(31, 10, 29, 1, 0, 0, 0), 32'd1, 32'd0, 1, 0, 0, "R1");
    // R12 destination index extremes
    send(mk(31, 138, 31, 5, 6, 0, 0), 32'd1, 32'd2, 0, 0, 0, "R12");
    send(mk(31, 138, 0, 5, 6, 0, 0), 32'd1, 32'd2, 0, 0, 0, "R12");
    // R11 gap then back-to-back
    idleCheck();
    send(mk(31, 234, 1, 1, 0, 0, 0), 32'd2, 32'd0, 0, 0, 0, "R11");
    send(mk(31, 202, 2, 1, 0, 0, 0), 32'd2, 32'd0, 1, 0, 0, "R11");
    idleCheck();

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R11", "pending results", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule